// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer with Serial Readout

This block is the digital half of a 10-bit successive-approximation converter that is read over three wires. A falling edge on the active-low select puts the sampling switch into hold and starts a conversion. The conversion then runs by itself, one step per pulse of a conversion-rate enable, and needs no serial clock. Each step places a trial code on the capacitive DAC and keeps or drops the trial bit according to the comparator. After the ten result bits, two extra steps below LSB weight resolve two sub-bits.

The serial line is driven low for as long as the conversion runs. When the conversion is done, the line goes high to mark its end, and the sampling switch returns to track. Each later falling edge of the serial clock then presents the next bit: the ten result bits MSB first, the two sub-bits, and zeros after that. Raising the select releases the line to high impedance and aborts any conversion in progress. Holding the active-low shutdown input low parks the block in a powered-down state in which the select is ignored.

Select, serial clock and shutdown come from pins. They are synchronized into the core clock domain, and their edges are detected there. The pad itself is outside the block: it drives the data bit when the output enable is high.

Top module: `sarSerialAdc`

## Requirements
- R1: When the block is powered and idle, a falling edge on `csN` raises `holdOn` and turns on `doutOe`, with `doutBit` low.
- R2: While a conversion runs, `doutBit` stays low and `doutOe` stays high. Falling edges of `sclk` during the conversion have no effect on the result.
- R3: After `RES_BITS+SUB_BITS` pulses of `convTick` the conversion ends. `doutBit` goes high as the end-of-conversion marker and `holdOn` falls.
- R4: Each bit of the result is decided in turn from the MSB downward. A trial bit is kept only when `cmpHigh` reports the input at or above `trialCode`, so the 12-bit result equals the ideal input code. Each code is plain unipolar binary.
- R5: After the marker, each falling edge of `sclk` presents the next frame bit on `doutBit`. The ten result bits come first, MSB first, followed by the two sub-bits.
- R6: Falling edges of `sclk` after the last sub-bit, while `csN` stays low, present zeros.
- R7: While `csN` is high and no conversion is running, `doutOe` is low.
- R8: Raising `csN` during a conversion aborts it. `holdOn` and `doutOe` drop, and `trialCode`, including the sub-bit positions, returns to 0.
- R9: While `shdnN` is low, a falling edge on `csN` starts no conversion: `holdOn` and `doutOe` stay low.
- R10: After reset, `holdOn` and `doutOe` are low and `trialCode` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low select from pin; its fall starts a conversion |
| sclk | input | 1 | Serial clock from pin; its falling edges advance the frame |
| shdnN | input | 1 | Active-low shutdown from pin |
| convTick | input | 1 | Conversion-rate enable, one SAR step per pulse |
| cmpHigh | input | 1 | Comparator result: input at or above the DAC level |
| holdOn | output | 1 | Sampling switch control, 1 = hold, 0 = track |
| trialCode | output | 12 | Trial code to the capacitive DAC (result bits then sub-bits) |
| doutBit | output | 1 | Serial data bit to the pad |
| doutOe | output | 1 | Pad output enable; low means high impedance |

## Verification
The bench builds the block with its defaults: 10 result bits, 2 sub-bits and a two-stage synchronizer. The ideal comparator is then a plain compare against a 12-bit input code, and every frame bit can be predicted exactly. Applying a conversion pulse every fourth core clock lets the whole twelve-step conversion, the abort point and the synchronizer latency fit in short fixed waits. The cases reached are the all-zeros and all-ones codes, mid-scale, a mixed pattern, serial-clock activity during a conversion, an abort after a few steps, and shutdown.

// File: rtl/sarAdcPkg.sv
package sarAdcPkg;
  typedef struct packed {
    logic start;
    logic step;
    logic abort;
    logic shift;
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    ST_OFF,
    ST_IDLE,
    ST_CONV,
    ST_READ
  } ctrlState_t;
endpackage

// File: rtl/sarInSync.sv
module sarInSync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/sarCtrl.sv
module sarCtrl
  import sarAdcPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         csNS,
  input  logic         sclkS,
  input  logic         shdnNS,
  input  logic         convTick,
  input  logic         lastStep,
  output ctrlStrobes_t strb,
  output logic         holdOn,
  output logic         doutOe
);
  ctrlState_t state, nextState;
  logic csPrev, sclkPrev;
  logic csFall, csRise, sclkFall;

  assign csFall   = csPrev & ~csNS;
  assign csRise   = ~csPrev & csNS;
  assign sclkFall = sclkPrev & ~sclkS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      state    <= nextState;
      csPrev   <= csNS;
      sclkPrev <= sclkS;
    end
  end

  always_comb begin
    nextState = state;
    strb = '0;
    case (state)
      ST_OFF: if (shdnNS) nextState = ST_IDLE;
      ST_IDLE: begin
        if (!shdnNS) nextState = ST_OFF;
        else if (csFall) begin
          strb.start = 1'b1;
          nextState = ST_CONV;
        end
      end
      ST_CONV: begin
        if (csRise || !shdnNS) begin
          strb.abort = 1'b1;
          nextState = shdnNS ? ST_IDLE : ST_OFF;
        end else if (convTick) begin
          strb.step = 1'b1;
          if (lastStep) nextState = ST_READ;
        end
      end
      ST_READ: begin
        if (!shdnNS) begin
          strb.abort = 1'b1;
          nextState = ST_OFF;
        end else if (csRise) nextState = ST_IDLE;
        else if (sclkFall) strb.shift = 1'b1;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign holdOn = (state == ST_CONV);
  assign doutOe = (state == ST_CONV) || (state == ST_READ);

  a_r9_no_start_in_off: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OFF) |=> (state != ST_CONV));
  a_r7_idle_needs_fall: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && csNS) |=> (state != ST_CONV));
endmodule

// File: rtl/sarDatapath.sv
module sarDatapath
  import sarAdcPkg::*;
#(
  parameter int RES_BITS = 10,
  parameter int SUB_BITS = 2,
  localparam int CODE_W = RES_BITS + SUB_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic              cmpHigh,
  output logic [CODE_W-1:0] trialCode,
  output logic              lastStep,
  output logic              doutBit
);
  localparam logic [CODE_W-1:0] TOP_BIT = {1'b1, {(CODE_W-1){1'b0}}};

  logic [CODE_W-1:0] code, mask;
  logic [CODE_W:0]   frame;
  logic [CODE_W-1:0] nextCode;

  assign nextCode = cmpHigh ? (code | mask) : code;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      code  <= '0;
      mask  <= '0;
      frame <= '0;
    end else if (strb.abort) begin
      code  <= '0;
      mask  <= '0;
      frame <= '0;
    end else if (strb.start) begin
      code  <= '0;
      mask  <= TOP_BIT;
      frame <= '0;
    end else if (strb.step) begin
      code <= nextCode;
      mask <= mask >> 1;
      if (mask[0]) frame <= {1'b1, nextCode};
    end else if (strb.shift) begin
      frame <= {frame[CODE_W-1:0], 1'b0};
    end
  end

  assign trialCode = code | mask;
  assign lastStep  = mask[0];
  assign doutBit   = frame[CODE_W];

  a_r8_abort_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.abort |=> (trialCode == '0 && !doutBit));
  a_r5_frame_moves_on_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (strb == '0) |=> $stable(frame));
  a_r4_one_mask_bit: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(mask));
endmodule

// File: rtl/sarSerialAdc.sv
module sarSerialAdc
  import sarAdcPkg::*;
#(
  parameter int RES_BITS = 10,
  parameter int SUB_BITS = 2,
  parameter int SYNC_STAGES = 2,
  localparam int CODE_W = RES_BITS + SUB_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              shdnN,
  input  logic              convTick,
  input  logic              cmpHigh,
  output logic              holdOn,
  output logic [CODE_W-1:0] trialCode,
  output logic              doutBit,
  output logic              doutOe
);
  logic [2:0] pinSync;
  ctrlStrobes_t strb;
  logic lastStep;

  sarInSync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b101)) uSync (
    .clk(clk), .rstN(rstN), .din({shdnN, sclk, csN}), .dout(pinSync)
  );

  sarCtrl uCtrl (
    .clk(clk), .rstN(rstN), .csNS(pinSync[0]), .sclkS(pinSync[1]),
    .shdnNS(pinSync[2]), .convTick(convTick), .lastStep(lastStep),
    .strb(strb), .holdOn(holdOn), .doutOe(doutOe)
  );

  sarDatapath #(.RES_BITS(RES_BITS), .SUB_BITS(SUB_BITS)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .cmpHigh(cmpHigh),
    .trialCode(trialCode), .lastStep(lastStep), .doutBit(doutBit)
  );

  a_r2_low_while_hold: assert property (@(posedge clk) disable iff (!rstN)
    holdOn |-> (doutOe && !doutBit));
  a_r3_eoc_marker: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(holdOn) && doutOe) |-> doutBit);
endmodule

// File: tb/sarSerialAdc_test.sv
module sarSerialAdc_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sclk = 1'b0, shdnN = 1'b1, convTick = 1'b0;
  logic [11:0] vin = '0;
  logic holdOn, doutBit, doutOe, cmpHigh;
  logic [11:0] trialCode;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign cmpHigh = (vin >= trialCode);

  sarSerialAdc uut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .shdnN(shdnN),
    .convTick(convTick), .cmpHigh(cmpHigh), .holdOn(holdOn),
    .trialCode(trialCode), .doutBit(doutBit), .doutOe(doutOe)
  );

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      convTick = 1'b1;
      @(negedge clk);
      convTick = 1'b0;
    end
  end

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sclkFall();
    sclk = 1'b1; waitClk(4);
    sclk = 1'b0; waitClk(6);
  endtask

  task automatic tReset();
    chk("R10 hold", holdOn, 0);
    chk("R10 oe", doutOe, 0);
    chk("R10 code", trialCode, 0);
    chk("R7 idle oe", doutOe, 0);
  endtask

  task automatic runConv(logic [11:0] v, bit toggle);
    vin = v;
    csN = 1'b0; waitClk(6);
    chk("R1 hold", holdOn, 1);
    chk("R1 oe", doutOe, 1);
    chk("R1 dout low", doutBit, 0);
    if (toggle) begin
      for (int i = 0; i < 6; i++) begin sclk = 1'b1; waitClk(2); sclk = 1'b0; waitClk(2); end
      chk("R2 dout low mid", doutBit, 0);
      chk("R2 oe mid", doutOe, 1);
      waitClk(50);
    end else waitClk(74);
    chk("R3 marker", doutBit, 1);
    chk("R3 track", holdOn, 0);
    for (int i = 1; i <= 14; i++) begin
      sclkFall();
      if (i <= 10) chk("R5 R4 result bit", doutBit, v[12-i]);
      else if (i <= 12) chk("R5 sub bit", doutBit, v[12-i]);
      else chk("R6 trailing zero", doutBit, 0);
    end
    csN = 1'b1; waitClk(6);
    chk("R7 hiz", doutOe, 0);
  endtask

  task automatic tAbort();
    vin = 12'hFFF;
    csN = 1'b0; waitClk(22);
    chk("R8 running", holdOn, 1);
    csN = 1'b1; waitClk(6);
    chk("R8 hold", holdOn, 0);
    chk("R8 oe", doutOe, 0);
    chk("R8 code cleared", trialCode, 0);
    waitClk(10);
    runConv(12'h3C9, 0);
  endtask

  task automatic tShutdown();
    shdnN = 1'b0; waitClk(6);
    csN = 1'b0; waitClk(80);
    chk("R9 hold", holdOn, 0);
    chk("R9 oe", doutOe, 0);
    csN = 1'b1; waitClk(4);
    shdnN = 1'b1; waitClk(6);
    runConv(12'h801, 0);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    waitClk(3);
    rstN = 1'b1;
    waitClk(4);
    tReset();
    runConv(12'h000, 0);
    runConv(12'hFFF, 0);
    runConv(12'h800, 0);
    runConv(12'h5A6, 1);
    tAbort();
    tShutdown();
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end
endmodule